// File: doc/BRIEF.md
# Strobe-driven byte port to an on-chip static RAM with pointer and XOR checksum

This block is a byte-wide front end between a host bus and an internal static RAM. The host selects the block with a pair of chip selects: one active high, one active low. It then issues operations one strobe pulse at a time. Two mode inputs, read/write and data/command, choose among four operations: command write, data write, data read and checksum read.

Command writes build a table pointer a byte at a time. A rotating slot index steers each byte to the pointer's low, middle or high byte, or to a fourth mode slot that is accepted and discarded. Data reads and writes access the RAM at the pointer, advance the pointer by one, and fold the byte into a running XOR checksum. The host reads that checksum back to verify a transfer. The strobe is sampled by the block clock, and every operation takes effect on a sampled low-to-high strobe transition.

Top module: `cmd_sram_port`

## Requirements
- R1: The block is selected only while `sel_hi` is 1 and `sel_lo_n` is 0. While it is not selected, strobe transitions change no state and `dout_en` is 0.
- R2: An operation takes effect on the first clock edge at which `strobe` is sampled high after being sampled low. The mode `{rw_n, dc}` selects the operation: 00 is command write, 01 is data write, 11 is data read and 10 is checksum read.
- R3: Successive command writes go to pointer bits 7..0, then 15..8, then 23..16, then a discarded mode slot, and then back to bits 7..0. Writing 0x00, 0x01 and 0x02 in that order gives a pointer of 0x020100.
- R4: The slot index returns to the low pointer byte when the block is newly selected, and after every data read or data write.
- R5: The pointer increases by one, wrapping at 24 bits, after every data read and every data write. Checksum reads leave it unchanged.
- R6: The checksum is the XOR of every byte written to or read from the RAM. A command write to any of the three pointer slots clears it to zero. It cannot be written directly.
- R7: In checksum-read mode, `dout` carries the checksum and `dout_en` is 1. A checksum-read strobe changes neither the pointer nor the checksum.
- R8: The RAM is indexed by the low `RAM_AW` pointer bits (8 by default). Higher pointer bits are stored but take no part in addressing.
- R9: In data-read mode while selected, `dout` shows the RAM byte at the current pointer and `dout_en` is 1. That byte is folded into the checksum at the strobe's rising transition.
- R10: After reset the pointer, the checksum and the slot index are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_hi | input | 1 | Active-high chip select |
| sel_lo_n | input | 1 | Active-low chip select |
| strobe | input | 1 | Operation strobe; acts on its low-to-high transition |
| rw_n | input | 1 | 1 = read, 0 = write |
| dc | input | 1 | 1 = data (RAM), 0 = command/checksum |
| din | input | DATA_W | Write byte |
| dout | output | DATA_W | Read byte: RAM data or checksum |
| dout_en | output | 1 | Read-data output enable |

## Verification
A full fill of the RAM through sequential data writes, checked by reading it all back, tests pointer increment and checksum folding together. Directed command sequences tell correct slot rotation apart from a fixed or misordered slot index: five-byte sequences reach the mode slot and its wrap, and deselect/reselect and data accesses show the slot reset. Pointers at the 8-bit and 24-bit wrap, and pointers that differ only in their high byte, separate correct RAM indexing from use of the wrong bits. A long seeded random mix of the four operations, chip-select combinations and deselected strobes is compared against a bench model and exposes ignored-edge and checksum-clearing faults.

// File: rtl/cmd_sram_pkg.sv
package cmd_sram_pkg;

  // Operation code is the concatenation {rw_n, dc}
  typedef enum logic [1:0] {
    OP_CMD_WR  = 2'b00,
    OP_DAT_WR  = 2'b01,
    OP_CSUM_RD = 2'b10,
    OP_DAT_RD  = 2'b11
  } op_e;

endpackage

// File: rtl/cmd_sram_front.sv
// Chip-select decode, synchronous strobe edge detection and new-selection detection.
module cmd_sram_front (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_hi,
  input  logic sel_lo_n,
  input  logic strobe,
  output logic sel,
  output logic fire,
  output logic new_sel
);

  logic strobe_q, strobe_d;
  logic sel_q, sel_d;

  always_comb begin
    sel      = sel_hi & ~sel_lo_n;
    fire     = sel & strobe & ~strobe_q;
    new_sel  = sel & ~sel_q;
    strobe_d = strobe;
    sel_d    = sel;
  end

  // strobe history resets high so a strobe held high through reset does not fire
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b1;
      sel_q    <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
      sel_q    <= sel_d;
    end
  end

endmodule

// File: rtl/cmd_sram_regs.sv
// Table pointer, rotating slot index and XOR checksum.
module cmd_sram_regs
  import cmd_sram_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PTR_BYTES = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fire,
  input  logic                        new_sel,
  input  op_e                         op,
  input  logic [DATA_W-1:0]           din,
  input  logic [DATA_W-1:0]           rdata,
  output logic [DATA_W*PTR_BYTES-1:0] ptr,
  output logic [DATA_W-1:0]           csum
);

  localparam int PTR_W  = DATA_W * PTR_BYTES;
  localparam int NSLOT  = PTR_BYTES + 1;          // pointer bytes plus mode slot
  localparam int SLOT_W = $clog2(NSLOT);
  localparam logic [SLOT_W-1:0] SLOT_MODE = SLOT_W'(PTR_BYTES);

  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [DATA_W-1:0] csum_q, csum_d;
  logic [SLOT_W-1:0] slot_q, slot_d, slot_eff;
  logic [PTR_W-1:0]  ptr_loaded;

  assign slot_eff = new_sel ? '0 : slot_q;

  // Byte-lane replacement of the pointer for command writes
  generate
    for (genvar b = 0; b < PTR_BYTES; b++) begin : g_lane
      assign ptr_loaded[b*DATA_W +: DATA_W] =
        (slot_eff == SLOT_W'(b)) ? din : ptr_q[b*DATA_W +: DATA_W];
    end
  endgenerate

  always_comb begin
    ptr_d  = ptr_q;
    csum_d = csum_q;
    slot_d = slot_eff;
    if (fire) begin
      unique case (op)
        OP_CMD_WR: begin
          ptr_d = ptr_loaded;
          if (slot_eff != SLOT_MODE) csum_d = '0;
          slot_d = (slot_eff == SLOT_MODE) ? '0 : slot_eff + SLOT_W'(1);
        end
        OP_DAT_WR: begin
          csum_d = csum_q ^ din;
          ptr_d  = ptr_q + PTR_W'(1);
          slot_d = '0;
        end
        OP_DAT_RD: begin
          csum_d = csum_q ^ rdata;
          ptr_d  = ptr_q + PTR_W'(1);
          slot_d = '0;
        end
        OP_CSUM_RD: begin
          slot_d = slot_eff;
        end
        default: slot_d = slot_eff;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      csum_q <= '0;
      slot_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      csum_q <= csum_d;
      slot_q <= slot_d;
    end
  end

  assign ptr  = ptr_q;
  assign csum = csum_q;

endmodule

// File: rtl/cmd_sram_mem.sv
// Behavioural byte array: synchronous write, combinational read.
module cmd_sram_mem #(
  parameter int DATA_W = 8,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[addr] <= wdata;
  end

  assign rdata = arr[addr];

endmodule

// File: rtl/cmd_sram_port.sv
module cmd_sram_port
  import cmd_sram_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PTR_BYTES = 3,
  parameter int RAM_AW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_hi,
  input  logic              sel_lo_n,
  input  logic              strobe,
  input  logic              rw_n,
  input  logic              dc,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  localparam int PTR_W = DATA_W * PTR_BYTES;

  logic              sel, fire, new_sel;
  op_e               op;
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] csum_q;
  logic [DATA_W-1:0] rdata;
  logic              mem_we;

  assign op     = op_e'({rw_n, dc});
  assign mem_we = fire && (op == OP_DAT_WR);

  cmd_sram_front u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_hi   (sel_hi),
    .sel_lo_n (sel_lo_n),
    .strobe   (strobe),
    .sel      (sel),
    .fire     (fire),
    .new_sel  (new_sel)
  );

  cmd_sram_regs #(
    .DATA_W    (DATA_W),
    .PTR_BYTES (PTR_BYTES)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .new_sel (new_sel),
    .op      (op),
    .din     (din),
    .rdata   (rdata),
    .ptr     (ptr_q),
    .csum    (csum_q)
  );

  cmd_sram_mem #(
    .DATA_W (DATA_W),
    .AW     (RAM_AW)
  ) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (ptr_q[RAM_AW-1:0]),
    .wdata (din),
    .rdata (rdata)
  );

  assign dout    = (op == OP_DAT_RD) ? rdata : csum_q;
  assign dout_en = sel & rw_n;

endmodule

// File: rtl/cmd_sram_chk.sv
module cmd_sram_chk #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_hi,
  input logic              sel_lo_n,
  input logic              strobe,
  input logic              rw_n,
  input logic              dc,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic [PTR_W-1:0]  ptr,
  input logic [DATA_W-1:0] csum
);

  logic stb_seen;
  logic selected, edge_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_seen <= 1'b1;
    else        stb_seen <= strobe;
  end

  assign selected = sel_hi && !sel_lo_n;
  assign edge_ok  = selected && strobe && !stb_seen;

  a_r1_bus_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !selected |-> !dout_en);

  a_r2_no_edge_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_ok |=> ($stable(ptr) && $stable(csum)));

  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ok && dc) |=> (ptr == $past(ptr) + PTR_W'(1)));

  a_r6_write_fold: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ok && dc && !rw_n) |=> (csum == ($past(csum) ^ $past(din))));

  a_r9_read_fold: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ok && dc && rw_n) |=> (csum == ($past(csum) ^ $past(dout))));

  a_r7_csum_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ok && rw_n && !dc) |=> ($stable(ptr) && $stable(csum)));

endmodule

bind cmd_sram_port cmd_sram_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_hi   (sel_hi),
  .sel_lo_n (sel_lo_n),
  .strobe   (strobe),
  .rw_n     (rw_n),
  .dc       (dc),
  .din      (din),
  .dout     (dout),
  .dout_en  (dout_en),
  .ptr      (ptr_q),
  .csum     (csum_q)
);

// File: tb/cmd_sram_port_tb.sv
module cmd_sram_port_tb;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel_hi, sel_lo_n, strobe, rw_n, dc;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench model
  logic [7:0]  m_mem [256];
  logic [23:0] m_ptr;
  logic [7:0]  m_csum;
  int          m_slot;
  bit          m_sel;

  always #10 clk = ~clk;

  cmd_sram_port u_dut (
    .clk(clk), .rst_n(rst_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .strobe(strobe), .rw_n(rw_n), .dc(dc), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ram_byte();
    return m_mem[m_ptr[7:0]];
  endfunction

  task automatic set_sel(input logic h, input logic ln);
    bit now;
    @(negedge clk);
    sel_hi = h; sel_lo_n = ln; rw_n = 1'b1;
    now = h && !ln;
    if (now && !m_sel) m_slot = 0;
    m_sel = now;
    @(negedge clk);
    if (!now) check("R1 dout_en while deselected", dout_en, 0);
  endtask

  // one strobe pulse with mode {r, d}; reads are checked while strobe is low
  task automatic do_op(input logic r, input logic d, input logic [7:0] v, input string req);
    @(negedge clk);
    rw_n = r; dc = d; din = v; strobe = 1'b0;
    @(negedge clk);
    if (m_sel && r) begin
      check({req, " dout_en"}, dout_en, 1);
      check({req, " dout"}, dout, d ? exp_ram_byte() : m_csum);
    end
    strobe = 1'b1;
    @(negedge clk);
    if (m_sel) begin
      case ({r, d})
        2'b00: begin
          if (m_slot < 3) begin
            m_ptr[m_slot*8 +: 8] = v;
            m_csum = 8'h00;
          end
          m_slot = (m_slot == 3) ? 0 : m_slot + 1;
        end
        2'b01: begin
          m_mem[m_ptr[7:0]] = v; m_csum ^= v; m_ptr += 24'd1; m_slot = 0;
        end
        2'b11: begin
          m_csum ^= m_mem[m_ptr[7:0]]; m_ptr += 24'd1; m_slot = 0;
        end
        default: ;
      endcase
    end
  endtask

  task automatic set_ptr(input logic [23:0] p, input string req);
    do_op(1'b1, 1'b1, 8'h00, {req, " slot reset read"});
    do_op(1'b0, 1'b0, p[7:0], req);
    do_op(1'b0, 1'b0, p[15:8], req);
    do_op(1'b0, 1'b0, p[23:16], req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_0a27));
    rst_n = 1'b0; sel_hi = 1'b0; sel_lo_n = 1'b1; strobe = 1'b1;
    rw_n = 1'b1; dc = 1'b0; din = '0;
    m_ptr = '0; m_csum = '0; m_slot = 0; m_sel = 1'b0;
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 dout_en before select", dout_en, 0);

    // R10: reset checksum, then fill whole RAM from pointer zero
    set_sel(1'b1, 1'b0);
    do_op(1'b1, 1'b0, 8'h00, "R10 reset checksum");
    for (int i = 0; i < 256; i++) do_op(1'b0, 1'b1, 8'($urandom), "R5 fill");
    do_op(1'b1, 1'b0, 8'h00, "R6 checksum after fill");
    for (int i = 0; i < 256; i++) do_op(1'b1, 1'b1, 8'h00, "R9 readback");
    do_op(1'b1, 1'b0, 8'h00, "R7 checksum after readback");
    do_op(1'b1, 1'b0, 8'h00, "R7 repeated checksum read");

    // R3: bytes 00,01,02 give 0x020100; checksum cleared by command write (R6)
    set_ptr(24'h020100, "R3");
    check("R3 pointer low bits", m_ptr, 24'h020100);
    do_op(1'b1, 1'b0, 8'h00, "R6 cleared by command write");
    do_op(1'b1, 1'b1, 8'h00, "R3 read at 0x020100");
    // five command writes: fifth wraps past mode slot to low byte
    do_op(1'b0, 1'b0, 8'h11, "R3"); do_op(1'b0, 1'b0, 8'h00, "R3");
    do_op(1'b0, 1'b0, 8'h07, "R3"); do_op(1'b0, 1'b0, 8'hA5, "R3 mode slot");
    do_op(1'b0, 1'b0, 8'h40, "R3 wrap");
    do_op(1'b1, 1'b1, 8'h00, "R3 read after wrap");

    // R4: reselection resets slot
    do_op(1'b0, 1'b0, 8'h33, "R4");
    set_sel(1'b0, 1'b0);
    set_sel(1'b1, 1'b0);
    do_op(1'b0, 1'b0, 8'h90, "R4 after reselect");
    do_op(1'b1, 1'b1, 8'h00, "R4 read after reselect");
    // R4: data write resets slot
    do_op(1'b0, 1'b0, 8'h21, "R4");
    do_op(1'b0, 1'b1, 8'h6C, "R4 data write");
    do_op(1'b0, 1'b0, 8'h21, "R4 low slot after write");
    do_op(1'b1, 1'b1, 8'h00, "R4 read back written byte");

    // R5: 8-bit index wrap and 24-bit wrap
    set_ptr(24'h0000FF, "R5");
    do_op(1'b1, 1'b1, 8'h00, "R5 read at 0xFF");
    do_op(1'b1, 1'b1, 8'h00, "R5 read after index wrap");
    set_ptr(24'hFFFFFF, "R5");
    do_op(1'b1, 1'b1, 8'h00, "R5 read at top");
    do_op(1'b1, 1'b1, 8'h00, "R5 read after 24-bit wrap");
    check("R5 model pointer wrapped", m_ptr, 24'h000001);

    // R8: only low bits address the RAM
    set_ptr(24'h000010, "R8");
    do_op(1'b0, 1'b1, 8'hC3, "R8 write");
    set_ptr(24'h5A3710, "R8");
    do_op(1'b1, 1'b1, 8'h00, "R8 alias read");
    check("R8 alias byte", m_mem[8'h10], 8'hC3);

    // R1: strobes while deselected are ignored
    set_sel(1'b1, 1'b1);
    do_op(1'b0, 1'b1, 8'hEE, "R1 ignored write");
    do_op(1'b0, 1'b0, 8'hEE, "R1 ignored command");
    set_sel(1'b1, 1'b0);
    do_op(1'b1, 1'b0, 8'h00, "R1 checksum unchanged");
    do_op(1'b1, 1'b1, 8'h00, "R1 RAM unchanged");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      int k;
      k = int'($urandom_range(0, 19));
      if (k == 0) begin
        int c;
        c = int'($urandom_range(0, 3));
        set_sel(c[1], c[0]);
      end else if (k == 1) begin
        set_sel(1'b1, 1'b0);
      end else begin
        logic [1:0] md;
        md = 2'($urandom);
        do_op(md[1], md[0], 8'($urandom), "R2 random op");
      end
    end
    set_sel(1'b1, 1'b0);
    do_op(1'b1, 1'b0, 8'h00, "R6 final checksum");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule